// File: doc/BRIEF.md
# Multi-Unit Issue Hazard Controller

This block sits at the issue point of an in-order pipeline. The pipeline has one integer unit and three long-latency arithmetic units: an adder, a multiplier and a divider. Each cycle the block looks at one presented instruction, given as an operation class, two source register indices and a destination index. It then decides whether the instruction may leave for its unit this cycle or must wait. It tracks two hazards at once. The first is result readiness: every register carries a pending count, loaded with the producer's latency when the producer issues. The second is unit occupancy: a unit whose initiation interval is longer than one cycle carries a busy count, so that it cannot be reissued early.

The instruction arrives on a valid/ready stream. The transfer (the issue) happens in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is computed from the presented payload and the internal counts. It does not depend on `in_valid`. Once `in_valid` is raised, the source must hold the payload steady until the transfer. Because there is one input and no skid storage, a stalled instruction blocks every later one, and issue stays in program order. `stall` and `issue_unit` are plain status outputs.

Top module: `issue_hazard_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every pending count and busy count. In the first cycle after reset, `in_ready` is high for any presented operation and any source registers.
- R2: The operation class is coded on `in_op`: 0 integer, 1 load, 2 store, 3 add, 4 multiply, 5 divide. `issue_unit` names the unit as follows: 0 integer (integer, load, store), 1 adder, 2 multiplier, 3 divider.
- R3: With `in_valid` high, if either source register (`in_src1` or `in_src2`) has a nonzero pending count, then `in_ready` is low and `stall` is high.
- R4: At issue, the destination's pending count is loaded with the producer latency: integer 0, load 1, add 3 (four adder stages), multiply 6 (seven multiplier stages), divide 24. A dependent instruction presented in the cycle after the producer issues therefore stalls exactly that many cycles.
- R5: The divider is not pipelined and has an initiation interval of 24 cycles. A divide presented in the cycle after a divide issues stalls 23 cycles, even when it has no register dependence.
- R6: The adder and the multiplier are fully pipelined. Independent operations of the same class issue on consecutive cycles with no stall.
- R7: A store loads no pending count. Its destination field neither creates a hazard nor clears one already pending on that register.
- R8: `stall` equals `in_valid` and not `in_ready`, so `stall` is low whenever `in_valid` is low. A waiting instruction leaves no trace in the counts until it issues.
- R9: Every nonzero pending count falls by one each cycle, whether the input is stalled, idle or issuing. A consumer presented g cycles after its producer's issue cycle (g = 1 meaning the next cycle) stalls max(L - g + 1, 0) cycles.
- R10: The unused codes 6 and 7 behave as integer operations: unit 0 and latency 0.
- R11: A later producer of the same register overwrites its pending count with its own latency, even when that latency is shorter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented |
| in_ready | output | 1 | The presented instruction may issue this cycle |
| in_op | input | 3 | Operation class code |
| in_src1 | input | $clog2(NREG) | First source register index |
| in_src2 | input | $clog2(NREG) | Second source register index |
| in_dst | input | $clog2(NREG) | Destination register index |
| stall | output | 1 | Presented instruction is held this cycle |
| issue_unit | output | 2 | Unit chosen for the presented instruction |

## Verification
`in_ready`, `stall` and `issue_unit` are combinational in the presented payload and the current counts. The bench drives each instruction on a falling edge and reads these outputs 1 ns later, within the same cycle. Every count update lands on the rising edge that completes the transfer. A dependent instruction presented at the next falling edge therefore sees the count one cycle after the producer issued. The bench counts the cycles in which `in_ready` stays low and compares that number with a figure it computes from the latency, the interval and the number of idle cycles placed in between. These figures are swept over the producing class, the source slot and the idle gap.

// File: rtl/ihc_pkg.sv
`timescale 1ns/1ps
package ihc_pkg;
  typedef enum logic [2:0] {
    OP_INT   = 3'd0,
    OP_LOAD  = 3'd1,
    OP_STORE = 3'd2,
    OP_ADD   = 3'd3,
    OP_MUL   = 3'd4,
    OP_DIV   = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    U_INT = 2'd0,
    U_ADD = 2'd1,
    U_MUL = 2'd2,
    U_DIV = 2'd3
  } unit_e;

  localparam int NUM_UNITS = 4;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ihc_decode.sv
`timescale 1ns/1ps
module ihc_decode import ihc_pkg::*; #(
  parameter int LW         = 5,
  parameter int LAT_INT    = 0,
  parameter int LAT_LOAD   = 1,
  parameter int ADD_STAGES = 4,
  parameter int MUL_STAGES = 7,
  parameter int DIV_LAT    = 24
) (
  input  logic [2:0]    op,
  output unit_e         unit,
  output logic [LW-1:0] lat,
  output logic          wr_dst
);
  // Pipelined units: latency is one less than their stage count.
  localparam int LAT_ADD = ADD_STAGES - 1;
  localparam int LAT_MUL = MUL_STAGES - 1;

  always_comb begin
    unit   = U_INT;
    lat    = LW'(LAT_INT);
    wr_dst = 1'b1;
    case (op)
      OP_LOAD: begin
        lat = LW'(LAT_LOAD);
      end
      OP_STORE: begin
        lat    = '0;
        wr_dst = 1'b0;
      end
      OP_ADD: begin
        unit = U_ADD;
        lat  = LW'(LAT_ADD);
      end
      OP_MUL: begin
        unit = U_MUL;
        lat  = LW'(LAT_MUL);
      end
      OP_DIV: begin
        unit = U_DIV;
        lat  = LW'(DIV_LAT);
      end
      default: begin
        // integer and unused codes: integer unit, integer latency
        unit = U_INT;
        lat  = LW'(LAT_INT);
      end
    endcase
  end
endmodule

// File: rtl/ihc_scoreboard.sv
`timescale 1ns/1ps
module ihc_scoreboard #(
  parameter int NREG   = 32,
  parameter int LW     = 5,
  parameter int MAXLAT = 24,
  localparam int RW    = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_idx,
  input  logic [LW-1:0] wr_lat,
  input  logic [RW-1:0] rd_idx1,
  input  logic [RW-1:0] rd_idx2,
  output logic          pend1,
  output logic          pend2
);
  logic [LW-1:0] cnt_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_idx == RW'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q[i] <= '0;
      end else if (hit) begin
        cnt_q[i] <= wr_lat;
      end else if (cnt_q[i] != '0) begin
        cnt_q[i] <= cnt_q[i] - LW'(1);
      end
    end

    // R9: an untouched nonzero count falls by exactly one per cycle
    p_cnt_dec_r9: assert property (@(posedge clk) disable iff (rst)
      (!hit && cnt_q[i] != '0) |=> (cnt_q[i] == $past(cnt_q[i]) - LW'(1)));

    // R4: a count never exceeds the longest producer latency
    p_cnt_cap_r4: assert property (@(posedge clk) disable iff (rst)
      (cnt_q[i] <= LW'(MAXLAT)));
  end

  assign pend1 = (cnt_q[rd_idx1] != '0);
  assign pend2 = (cnt_q[rd_idx2] != '0);
endmodule

// File: rtl/ihc_unit_gate.sv
`timescale 1ns/1ps
module ihc_unit_gate #(
  parameter int II = 24,
  localparam int BW = $clog2(II)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  logic [BW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= BW'(II - 1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - BW'(1);
    end
  end

  assign busy = (cnt_q != '0);

  // R5: the unit is never started on two consecutive cycles
  p_reissue_gap_r5: assert property (@(posedge clk) disable iff (rst)
    start |=> !start);

  // R5: occupancy drains one cycle at a time
  p_busy_dec_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && !start) |=> (cnt_q == $past(cnt_q) - BW'(1)));
endmodule

// File: rtl/issue_hazard_ctrl.sv
`timescale 1ns/1ps
module issue_hazard_ctrl import ihc_pkg::*; #(
  parameter int NREG       = 32,
  parameter int LAT_INT    = 0,
  parameter int LAT_LOAD   = 1,
  parameter int ADD_STAGES = 4,
  parameter int MUL_STAGES = 7,
  parameter int DIV_LAT    = 24,
  parameter int ADD_II     = 1,
  parameter int MUL_II     = 1,
  parameter int DIV_II     = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [2:0]              in_op,
  input  logic [$clog2(NREG)-1:0] in_src1,
  input  logic [$clog2(NREG)-1:0] in_src2,
  input  logic [$clog2(NREG)-1:0] in_dst,
  output logic                    stall,
  output logic [1:0]              issue_unit
);
  localparam int MAXLAT = imax(imax(imax(LAT_INT, LAT_LOAD), imax(ADD_STAGES - 1, MUL_STAGES - 1)), DIV_LAT);
  localparam int LW     = $clog2(MAXLAT + 1);
  localparam int UNIT_II [NUM_UNITS] = '{1, ADD_II, MUL_II, DIV_II};

  unit_e                 sel_unit;
  logic [LW-1:0]         sel_lat;
  logic                  sel_wr;
  logic                  src1_pend;
  logic                  src2_pend;
  logic [NUM_UNITS-1:0]  unit_busy;
  logic                  fire;

  ihc_decode #(
    .LW(LW), .LAT_INT(LAT_INT), .LAT_LOAD(LAT_LOAD),
    .ADD_STAGES(ADD_STAGES), .MUL_STAGES(MUL_STAGES), .DIV_LAT(DIV_LAT)
  ) i_decode (
    .op(in_op), .unit(sel_unit), .lat(sel_lat), .wr_dst(sel_wr)
  );

  ihc_scoreboard #(.NREG(NREG), .LW(LW), .MAXLAT(MAXLAT)) i_score (
    .clk(clk), .rst(rst),
    .wr_en(fire && sel_wr), .wr_idx(in_dst), .wr_lat(sel_lat),
    .rd_idx1(in_src1), .rd_idx2(in_src2),
    .pend1(src1_pend), .pend2(src2_pend)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    if (UNIT_II[u] > 1) begin : g_gate
      ihc_unit_gate #(.II(UNIT_II[u])) i_gate (
        .clk(clk), .rst(rst),
        .start(fire && (sel_unit == unit_e'(u))),
        .busy(unit_busy[u])
      );
    end else begin : g_free
      assign unit_busy[u] = 1'b0;
    end
  end

  assign in_ready   = !src1_pend && !src2_pend && !unit_busy[sel_unit];
  assign fire       = in_valid && in_ready;
  assign stall      = in_valid && !in_ready;
  assign issue_unit = sel_unit;

  // R3: a pending source always blocks the presented instruction
  p_src_stall_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (src1_pend || src2_pend)) |-> !in_ready);

  // R1: the cycle after a reset edge starts with no pending work
  p_clear_r1: assert property (@(posedge clk)
    rst |=> (unit_busy == '0 && !src1_pend && !src2_pend));
endmodule

// File: tb/test_issue_hazard_ctrl.sv
`timescale 1ns/1ps
module test_issue_hazard_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [2:0] in_op = 3'd0;
  logic [4:0] in_src1 = 5'd0;
  logic [4:0] in_src2 = 5'd0;
  logic [4:0] in_dst = 5'd0;
  logic       stall;
  logic [1:0] issue_unit;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  issue_hazard_ctrl i_issue_hazard_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_src1(in_src1), .in_src2(in_src2), .in_dst(in_dst),
    .stall(stall), .issue_unit(issue_unit)
  );

  function automatic int lat_of(input int op);
    case (op)
      1: return 1;
      3: return 3;
      4: return 6;
      5: return 24;
      default: return 0;
    endcase
  endfunction

  function automatic int unit_of(input int op);
    case (op)
      3: return 1;
      4: return 2;
      5: return 3;
      default: return 0;
    endcase
  endfunction

  task automatic check_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Present one instruction, hold it until it issues, return stall cycles.
  task automatic send(input int op, input int s1, input int s2, input int d,
                      output int stalls, output int unit, output int bad_flag);
    stalls = 0;
    bad_flag = 0;
    @(negedge clk);
    in_valid = 1'b1;
    in_op = 3'(op);
    in_src1 = 5'(s1);
    in_src2 = 5'(s2);
    in_dst = 5'(d);
    #1;
    while (!in_ready) begin
      if (stall !== 1'b1) bad_flag = 1;
      stalls++;
      @(negedge clk);
      #1;
    end
    if (stall !== 1'b0) bad_flag = 1;
    unit = int'(issue_unit);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #1ms;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int st, un, bad;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check_eq("R8 stall low without valid", int'(stall), 0);

    // R1: every register is free right after reset
    for (int r = 0; r < 32; r++) begin
      in_valid = 1'b1; in_op = 3'd0; in_src1 = 5'(r); in_src2 = 5'(31 - r);
      #0.1;
      check_eq("R1 ready after reset", int'(in_ready), 1);
    end
    in_valid = 1'b0;

    // R2 / R10: unit selection for every code
    for (int op = 0; op < 8; op++) begin
      send(op, 1, 2, 20, st, un, bad);
      check_eq(op > 5 ? "R10 unused code unit" : "R2 unit select", un, unit_of(op));
      check_eq("R2 independent op no stall", st, 0);
      check_eq("R8 stall flag", bad, 0);
    end
    idle(30);

    // R4 / R3: latency per producing class, dependence via either source
    for (int k = 0; k < 5; k++) begin
      for (int slot = 0; slot < 2; slot++) begin
        int op;
        op = (k == 0) ? 0 : (k == 1) ? 1 : (k + 1);
        send(op, 1, 2, 8, st, un, bad);
        send(0, slot == 0 ? 8 : 3, slot == 0 ? 3 : 8, 21, st, un, bad);
        check_eq(slot == 0 ? "R4 R3 latency via src1" : "R4 R3 latency via src2", st, lat_of(op));
        check_eq("R8 stall flag", bad, 0);
        idle(30);
      end
    end

    // R9: counts keep falling over idle gaps
    for (int g = 0; g < 8; g++) begin
      send(4, 1, 2, 9, st, un, bad);
      idle(g);
      send(0, 9, 1, 22, st, un, bad);
      check_eq("R9 decay over idle gap", st, (6 - g > 0) ? 6 - g : 0);
    end
    idle(10);

    // R5: divider interval, then register latency dominates
    send(5, 1, 2, 10, st, un, bad);
    send(5, 3, 4, 11, st, un, bad);
    check_eq("R5 divide reissue stall", st, 23);
    send(5, 11, 1, 12, st, un, bad);
    check_eq("R5 R4 dependent divide", st, 24);
    idle(30);

    // R6: pipelined units back to back
    for (int k = 0; k < 2; k++) begin
      for (int n = 0; n < 3; n++) begin
        send(k == 0 ? 3 : 4, 1, 2, 13 + n, st, un, bad);
        check_eq("R6 back-to-back pipelined", st, 0);
      end
    end
    idle(10);

    // R7: store writes no count and leaves a pending one alone
    send(2, 1, 2, 16, st, un, bad);
    send(0, 16, 16, 0, st, un, bad);
    check_eq("R7 store dst not pending", st, 0);
    send(4, 1, 2, 17, st, un, bad);
    send(2, 1, 2, 17, st, un, bad);
    send(0, 17, 1, 0, st, un, bad);
    check_eq("R7 store keeps pending count", st, 5);
    idle(30);

    // R11: a shorter later producer overwrites
    send(5, 1, 2, 18, st, un, bad);
    send(0, 1, 2, 18, st, un, bad);
    send(0, 18, 1, 0, st, un, bad);
    check_eq("R11 overwrite by later producer", st, 0);
    idle(30);

    // R1: reset mid-flight clears counts and divider occupancy
    send(5, 1, 2, 19, st, un, bad);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    send(5, 19, 1, 0, st, un, bad);
    check_eq("R1 reset clears in-flight state", st, 0);

    summary();
    $finish;
  end
endmodule